// File: doc/BRIEF.md
# Trap return state restorer

This block performs the two trap-return operations of a processor core: "done" and "retry". When an operation is requested, it reads the saved context for the current trap level from an external trap-stack memory. That context is a packed trap-state word, a saved program counter, a saved next program counter and a saved hypervisor-state copy. In one commit the block unpacks these into the architectural registers and then lowers the trap level by one. The registers it restores are:

- the two program counters,
- the condition-code byte,
- the address-space identifier,
- the processor-state field,
- the window pointer,
- optionally, the global-register level and the hypervisor state.

The block also owns the banked global registers. A change of the bank-select bits in the processor state, or of the global level in level mode, redirects the global register port to another bank. The contents of the bank that was left are kept.

The saved-state read is synchronous, so block RAM can hold the trap stack. An accepted operation issues the read in its first cycle and commits on the next clock edge. A request at trap level zero is refused with an illegal-operation pulse.

Top module: `trp_restore`

## Requirements
- R1: After synchronous reset, pc, npc, ccr, asi, pstate, cwp, gl, hpstate and tl are all zero and illegal is low.
- R2: On done (op_retry=0), pc takes the saved next-PC and npc takes the saved next-PC plus 4, modulo 2^XLEN.
- R3: On retry (op_retry=1), pc takes the saved PC and npc takes the saved next-PC.
- R4: ccr is restored from trap-state bits [39:32], and asi from bits [31:24].
- R5: pstate is restored from trap-state bits [19:8] ANDed with 0xF3F. When gl_mode=1, pstate bits 0, 10 and 11 are additionally cleared.
- R6: cwp becomes NWIN-1 minus (trap-state bits [7:0] modulo NWIN).
- R7: When gl_mode=1, gl is restored from trap-state bits [42:40] and hpstate from rd_hstate. When gl_mode=0, gl and hpstate keep their values.
- R8: When gl_mode=0, the global bank follows the new pstate masked with 0xC01:
  - 0x000 selects bank 0 (normal);
  - 0x001 selects bank 1;
  - 0x400 selects bank 2;
  - 0x800 selects bank 3;
  - any other code selects bank 0.
- R9: When gl_mode=1, the global bank number equals the restored gl.
- R10: An accepted operation pulses rd_en with rd_lvl equal to the current tl. tl is one lower two clock edges after the request is sampled.
- R11: A request at tl=0 raises illegal for exactly one cycle, issues no read and changes no register.
- R12: A request presented in the cycle after an accepted one is ignored.
- R13: Global writes go to the active bank, and g_rd_data (one cycle of latency) reads the active bank. A bank keeps its contents while other banks are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Trap-return request |
| op_retry | input | 1 | 1 = retry, 0 = done |
| gl_mode | input | 1 | Global-level mode select, sampled at commit |
| tl_wr_en | input | 1 | Trap-level load from trap-entry logic |
| tl_wr_val | input | TLW | Trap level to load |
| rd_en | output | 1 | Saved-state read strobe |
| rd_lvl | output | TLW | Saved-state read index (trap level) |
| rd_tstate | input | 43 | Saved trap-state word, one cycle after rd_en |
| rd_tpc | input | XLEN | Saved PC |
| rd_tnpc | input | XLEN | Saved next PC |
| rd_hstate | input | HSW | Saved hypervisor state for the level |
| g_wr_en | input | 1 | Global register write enable |
| g_wr_idx | input | 3 | Global register write index |
| g_wr_data | input | XLEN | Global register write data |
| g_rd_idx | input | 3 | Global register read index |
| g_rd_data | output | XLEN | Registered global read data |
| pc | output | XLEN | Program counter |
| npc | output | XLEN | Next program counter |
| ccr | output | 8 | Condition codes |
| asi | output | 8 | Address-space identifier |
| pstate | output | 12 | Processor-state field |
| cwp | output | CWPW | Current window pointer |
| gl | output | 3 | Global level |
| hpstate | output | HSW | Hypervisor state |
| tl | output | TLW | Trap level |
| illegal | output | 1 | Illegal-operation pulse |

## Verification
The hardest situation to reach is a bank that was written, left for several others, and later re-entered through a select code the decoder does not recognise. Its contents must still be intact.

The stimulus builds this through a chain of retries. Each retry is loaded with a trap-state word whose processor-state bits pick a different bank, and a distinct value is written to the same register index in every bank. The chain ends with an unrecognised code, followed by a switch into level mode whose level number lands on a bank written earlier in legacy mode.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int TSW = 43;
  // trap-state word field positions
  localparam int GL_LO  = 40;
  localparam int CCR_LO = 32;
  localparam int ASI_LO = 24;
  localparam int PST_LO = 8;
  localparam logic [11:0] PST_KEEP = 12'hF3F;
  localparam logic [11:0] SEL_BITS = 12'hC01;

  typedef enum logic [2:0] {
    BANK_NORM = 3'd0,
    BANK_ALT  = 3'd1,
    BANK_MMU  = 3'd2,
    BANK_IRQ  = 3'd3
  } bank_e;

  function automatic logic [2:0] sel_to_bank(input logic [11:0] pst);
    logic [11:0] s;
    s = pst & SEL_BITS;
    case (s)
      12'h001: sel_to_bank = BANK_ALT;
      12'h400: sel_to_bank = BANK_MMU;
      12'h800: sel_to_bank = BANK_IRQ;
      default: sel_to_bank = BANK_NORM;
    endcase
  endfunction
endpackage

// File: rtl/trp_unpack.sv
module trp_unpack #(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic [trp_pkg::TSW-1:0] tstate,
  input  logic [XLEN-1:0]         tpc,
  input  logic [XLEN-1:0]         tnpc,
  input  logic                    retry,
  input  logic                    gl_mode,
  output logic [XLEN-1:0]         new_pc,
  output logic [XLEN-1:0]         new_npc,
  output logic [7:0]              new_ccr,
  output logic [7:0]              new_asi,
  output logic [11:0]             new_pst,
  output logic [CWPW-1:0]         new_cwp,
  output logic [2:0]              new_gl,
  output logic [2:0]              new_bank
);
  import trp_pkg::*;

  localparam logic [7:0] NW8 = 8'(NWIN);

  logic [11:0] pst_raw;
  logic [7:0]  wfield;
  logic [7:0]  wmod;

  assign wfield = tstate[7:0];

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      assign wmod = wfield & (NW8 - 8'd1);
    end else begin : g_mod
      assign wmod = wfield % NW8;
    end
  endgenerate

  always_comb begin
    new_pc  = retry ? tpc  : tnpc;
    new_npc = retry ? tnpc : tnpc + XLEN'(4);
    new_ccr = tstate[CCR_LO +: 8];
    new_asi = tstate[ASI_LO +: 8];
    new_gl  = tstate[GL_LO +: 3];
    pst_raw = tstate[PST_LO +: 12] & PST_KEEP;
    new_pst = gl_mode ? (pst_raw & ~SEL_BITS) : pst_raw;
    new_cwp = CWPW'(NW8 - 8'd1 - wmod);
    new_bank = gl_mode ? new_gl : sel_to_bank(pst_raw);
  end
endmodule

// File: rtl/trp_gbank.sv
module trp_gbank #(
  parameter int XLEN  = 64,
  parameter int NBANK = 8,
  parameter int NREG  = 8,
  localparam int BW = $clog2(NBANK),
  localparam int RW = $clog2(NREG),
  localparam int DEPTH = NBANK * NREG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bank_ld,
  input  logic [BW-1:0]   bank_nxt,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [RW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data
);
  logic [XLEN-1:0] mem [DEPTH];
  logic [BW-1:0]   bank_q;

  always_ff @(posedge clk) begin
    if (rst) bank_q <= '0;
    else if (bank_ld) bank_q <= bank_nxt;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{bank_q, wr_idx}] <= wr_data;
    rd_data <= mem[{bank_q, rd_idx}];
  end
endmodule

// File: rtl/trp_restore.sv
module trp_restore #(
  parameter int XLEN  = 64,
  parameter int MAXTL = 6,
  parameter int NWIN  = 8,
  parameter int HSW   = 12,
  localparam int TLW  = $clog2(MAXTL + 1),
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic                    op_retry,
  input  logic                    gl_mode,
  input  logic                    tl_wr_en,
  input  logic [TLW-1:0]          tl_wr_val,
  output logic                    rd_en,
  output logic [TLW-1:0]          rd_lvl,
  input  logic [trp_pkg::TSW-1:0] rd_tstate,
  input  logic [XLEN-1:0]         rd_tpc,
  input  logic [XLEN-1:0]         rd_tnpc,
  input  logic [HSW-1:0]          rd_hstate,
  input  logic                    g_wr_en,
  input  logic [2:0]              g_wr_idx,
  input  logic [XLEN-1:0]         g_wr_data,
  input  logic [2:0]              g_rd_idx,
  output logic [XLEN-1:0]         g_rd_data,
  output logic [XLEN-1:0]         pc,
  output logic [XLEN-1:0]         npc,
  output logic [7:0]              ccr,
  output logic [7:0]              asi,
  output logic [11:0]             pstate,
  output logic [CWPW-1:0]         cwp,
  output logic [2:0]              gl,
  output logic [HSW-1:0]          hpstate,
  output logic [TLW-1:0]          tl,
  output logic                    illegal
);
  logic            busy_q, retry_q, ill_q;
  logic            accept;
  logic [TLW-1:0]  tl_q;
  logic [XLEN-1:0] pc_q, npc_q, u_pc, u_npc;
  logic [7:0]      ccr_q, asi_q, u_ccr, u_asi;
  logic [11:0]     pst_q, u_pst;
  logic [CWPW-1:0] cwp_q, u_cwp;
  logic [2:0]      gl_q, u_gl, u_bank;
  logic [HSW-1:0]  hp_q;

  assign accept = op_valid & ~busy_q;
  assign rd_en  = accept & (tl_q != '0);
  assign rd_lvl = tl_q;

  trp_unpack #(.XLEN(XLEN), .NWIN(NWIN)) u_unpack (
    .tstate(rd_tstate), .tpc(rd_tpc), .tnpc(rd_tnpc),
    .retry(retry_q), .gl_mode(gl_mode),
    .new_pc(u_pc), .new_npc(u_npc), .new_ccr(u_ccr), .new_asi(u_asi),
    .new_pst(u_pst), .new_cwp(u_cwp), .new_gl(u_gl), .new_bank(u_bank)
  );

  trp_gbank #(.XLEN(XLEN), .NBANK(8), .NREG(8)) u_gbank (
    .clk(clk), .rst(rst),
    .bank_ld(busy_q), .bank_nxt(u_bank),
    .wr_en(g_wr_en), .wr_idx(g_wr_idx), .wr_data(g_wr_data),
    .rd_idx(g_rd_idx), .rd_data(g_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; retry_q <= 1'b0; ill_q <= 1'b0;
      tl_q <= '0; pc_q <= '0; npc_q <= '0; ccr_q <= '0; asi_q <= '0;
      pst_q <= '0; cwp_q <= '0; gl_q <= '0; hp_q <= '0;
    end else begin
      ill_q  <= accept & (tl_q == '0);
      busy_q <= rd_en;
      if (rd_en) retry_q <= op_retry;
      if (busy_q) begin
        pc_q  <= u_pc;
        npc_q <= u_npc;
        ccr_q <= u_ccr;
        asi_q <= u_asi;
        pst_q <= u_pst;
        cwp_q <= u_cwp;
        if (gl_mode) begin
          gl_q <= u_gl;
          hp_q <= rd_hstate;
        end
        tl_q <= tl_q - 1'b1;
      end else if (tl_wr_en) begin
        tl_q <= tl_wr_val;
      end
    end
  end

  assign pc = pc_q;  assign npc = npc_q;
  assign ccr = ccr_q; assign asi = asi_q;
  assign pstate = pst_q; assign cwp = cwp_q;
  assign gl = gl_q; assign hpstate = hp_q;
  assign tl = tl_q; assign illegal = ill_q;
endmodule

// File: rtl/trp_restore_chk.sv
module trp_restore_chk #(
  parameter int XLEN = 64,
  parameter int TLW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic            busy_q,
  input logic            retry_q,
  input logic [TLW-1:0]  tl,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] npc,
  input logic [XLEN-1:0] rd_tnpc,
  input logic            illegal
);
  a_r10_tl_dec: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (tl == $past(tl) - 1'b1));

  a_r11_refuse: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy_q && tl == '0) |=> (illegal && $stable(pc) && $stable(tl)));

  a_r2_done_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !retry_q) |=> (npc == pc + XLEN'(4)));

  a_r3_retry_npc: assert property (@(posedge clk) disable iff (rst)
    (busy_q && retry_q) |=> (npc == $past(rd_tnpc)));

  a_r12_single_commit: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
endmodule

bind trp_restore trp_restore_chk #(.XLEN(XLEN), .TLW(TLW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .busy_q(busy_q),
  .retry_q(retry_q), .tl(tl), .pc(pc), .npc(npc),
  .rd_tnpc(rd_tnpc), .illegal(illegal)
);

// File: tb/trp_restore_tb.sv
module trp_restore_tb;
  localparam int XLEN = 64;
  localparam int TLW  = 3;
  localparam int HSW  = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, op_valid, op_retry, gl_mode, tl_wr_en, rd_en, g_wr_en, illegal;
  logic [TLW-1:0]  tl_wr_val, rd_lvl, tl;
  logic [42:0]     rd_tstate;
  logic [XLEN-1:0] rd_tpc, rd_tnpc, g_wr_data, g_rd_data, pc, npc;
  logic [HSW-1:0]  rd_hstate, hpstate;
  logic [2:0]      g_wr_idx, g_rd_idx, gl, cwp;
  logic [7:0]      ccr, asi;
  logic [11:0]     pstate;

  trp_restore u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_retry(op_retry),
    .gl_mode(gl_mode), .tl_wr_en(tl_wr_en), .tl_wr_val(tl_wr_val),
    .rd_en(rd_en), .rd_lvl(rd_lvl), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc),
    .rd_tnpc(rd_tnpc), .rd_hstate(rd_hstate), .g_wr_en(g_wr_en),
    .g_wr_idx(g_wr_idx), .g_wr_data(g_wr_data), .g_rd_idx(g_rd_idx),
    .g_rd_data(g_rd_data), .pc(pc), .npc(npc), .ccr(ccr), .asi(asi),
    .pstate(pstate), .cwp(cwp), .gl(gl), .hpstate(hpstate), .tl(tl),
    .illegal(illegal)
  );

  // trap-stack model with synchronous read
  logic [42:0]     sv_ts  [8];
  logic [XLEN-1:0] sv_pc  [8];
  logic [XLEN-1:0] sv_npc [8];
  logic [HSW-1:0]  sv_hs  [8];
  int n_rd;
  always @(posedge clk) if (rd_en) begin
    rd_tstate <= sv_ts[rd_lvl];
    rd_tpc    <= sv_pc[rd_lvl];
    rd_tnpc   <= sv_npc[rd_lvl];
    rd_hstate <= sv_hs[rd_lvl];
    n_rd      <= n_rd + 1;
  end

  int tests = 0, fails = 0;
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {retry, mode, gl, ccr, asi, pst, cwpfield, exp_pst, exp_cwp}
  localparam logic [55:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd5, 8'hA5, 8'h80, 12'hFFF, 8'd0,   12'hF3F, 3'd7},
    {1'b1, 1'b0, 3'd2, 8'h3C, 8'h14, 12'h0C0, 8'd3,   12'h000, 3'd4},
    {1'b0, 1'b1, 3'd6, 8'h00, 8'hFF, 12'hC01, 8'd10,  12'h000, 3'd5},
    {1'b1, 1'b1, 3'd3, 8'h81, 8'h00, 12'h7FF, 8'd255, 12'h33E, 3'd0},
    {1'b0, 1'b0, 3'd7, 8'hFF, 8'h5A, 12'h135, 8'd7,   12'h135, 3'd0},
    {1'b1, 1'b0, 3'd1, 8'h10, 8'h01, 12'h800, 8'd9,   12'h800, 3'd6}
  };

  task automatic set_tl(input logic [TLW-1:0] v);
    @(negedge clk); tl_wr_en = 1'b1; tl_wr_val = v;
    @(negedge clk); tl_wr_en = 1'b0;
  endtask

  task automatic run_op(input logic r);
    @(negedge clk); op_valid = 1'b1; op_retry = r;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic gwrite(input logic [2:0] i, input logic [63:0] d);
    @(negedge clk); g_wr_en = 1'b1; g_wr_idx = i; g_wr_data = d;
    @(negedge clk); g_wr_en = 1'b0;
  endtask

  task automatic gread(input logic [2:0] i, output logic [63:0] d);
    @(negedge clk); g_rd_idx = i;
    @(negedge clk); d = g_rd_data;
  endtask

  task automatic swap(input logic m, input logic [2:0] g, input logic [11:0] p);
    set_tl(3'd1);
    sv_ts[1] = {g, 8'h00, 8'h00, 4'h0, p, 8'h00};
    gl_mode = m;
    run_op(1'b1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] rv;
    logic [2:0]  exp_gl;
    logic [11:0] exp_hs;
    n_rd = 0;
    rst = 1'b1; op_valid = 1'b0; op_retry = 1'b0; gl_mode = 1'b0;
    tl_wr_en = 1'b0; tl_wr_val = '0; g_wr_en = 1'b0; g_wr_idx = '0;
    g_wr_data = '0; g_rd_idx = '0;
    for (int k = 0; k < 8; k++) begin
      sv_ts[k] = '0; sv_pc[k] = '0; sv_npc[k] = '0; sv_hs[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 pc", pc, 0); check("R1 npc", npc, 0); check("R1 tl", 64'(tl), 0);
    check("R1 pstate", 64'(pstate), 0); check("R1 cwp", 64'(cwp), 0);
    check("R1 gl", 64'(gl), 0); check("R1 hpstate", 64'(hpstate), 0);
    check("R1 illegal", 64'(illegal), 0);

    // R11 refuse at level zero
    @(negedge clk); op_valid = 1'b1; op_retry = 1'b0;
    @(negedge clk); op_valid = 1'b0;
    check("R11 illegal pulse", 64'(illegal), 1);
    check("R11 no read", 64'(n_rd), 0);
    @(negedge clk);
    check("R11 pulse ends", 64'(illegal), 0);
    check("R11 pc kept", pc, 0); check("R11 tl kept", 64'(tl), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    exp_gl = 3'd0; exp_hs = '0;
    for (int i = 0; i < 6; i++) begin
      logic [55:0] v;
      logic [2:0]  lv;
      v  = VEC[i];
      lv = 3'(i % 6 + 1);
      sv_ts[lv]  = {v[53:51], v[50:43], v[42:35], 4'h0, v[34:23], v[22:15]};
      sv_pc[lv]  = 64'h1000_0000 + 64'(i) * 64'h100;
      sv_npc[lv] = 64'h2000_0000 + 64'(i) * 64'h10;
      sv_hs[lv]  = 12'h100 + 12'(i);
      gl_mode = v[54];
      set_tl(lv);
      run_op(v[55]);
      if (v[54]) begin exp_gl = v[53:51]; exp_hs = 12'h100 + 12'(i); end
      if (v[55]) begin
        check("R3 pc", pc, sv_pc[lv]); check("R3 npc", npc, sv_npc[lv]);
      end else begin
        check("R2 pc", pc, sv_npc[lv]); check("R2 npc", npc, sv_npc[lv] + 4);
      end
      check("R4 ccr", 64'(ccr), 64'(v[50:43]));
      check("R4 asi", 64'(asi), 64'(v[42:35]));
      check("R5 pstate", 64'(pstate), 64'(v[14:3]));
      check("R6 cwp", 64'(cwp), 64'(v[2:0]));
      check("R7 gl", 64'(gl), 64'(exp_gl));
      check("R7 hpstate", 64'(hpstate), 64'(exp_hs));
      check("R10 tl", 64'(tl), 64'(lv - 3'd1));
    end

    // R2 wrap of next-PC plus 4
    gl_mode = 1'b0;
    sv_ts[2] = '0; sv_npc[2] = '1; sv_pc[2] = 64'h55;
    set_tl(3'd2);
    run_op(1'b0);
    check("R2 wrap pc", pc, '1); check("R2 wrap npc", npc, 64'd3);

    // R12 request held into the busy cycle is ignored
    set_tl(3'd4);
    @(negedge clk); op_valid = 1'b1; op_retry = 1'b1;
    @(negedge clk);
    @(negedge clk); op_valid = 1'b0;
    check("R12 tl once", 64'(tl), 3);

    // R8 R9 R13 banks
    swap(1'b0, 3'd0, 12'h000); gwrite(3'd3, 64'hA0);
    swap(1'b0, 3'd0, 12'h001); gwrite(3'd3, 64'hA1);
    swap(1'b0, 3'd0, 12'h400); gwrite(3'd3, 64'hA2);
    swap(1'b0, 3'd0, 12'h800); gwrite(3'd3, 64'hA3);
    gread(3'd3, rv); check("R13 bank3 read", rv, 64'hA3);
    swap(1'b0, 3'd0, 12'h401); gread(3'd3, rv);
    check("R8 unknown code to normal", rv, 64'hA0);
    swap(1'b0, 3'd0, 12'h001); gread(3'd3, rv);
    check("R13 bank1 preserved", rv, 64'hA1);
    swap(1'b1, 3'd2, 12'h000); gread(3'd3, rv);
    check("R9 level selects bank", rv, 64'hA2);
    gwrite(3'd3, 64'hB2);
    swap(1'b0, 3'd0, 12'h800); gread(3'd3, rv);
    check("R8 irq bank", rv, 64'hA3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule